// File: doc/BRIEF.md
# Data TLB Miss Exception Entry Sequencer

This block performs the hardware side of entering a data TLB miss exception in a 32-bit RISC core. When the memory pipeline reports a translation miss, the block receives the faulting access's class, its PC and the PC of any enclosing delayed branch. It also receives a flag saying whether the access sat in a delay slot, and the current status register, general register 15 and vector base register. In a single accepting clock edge it records everything the handler needs and emits a one-cycle redirect to the handler entry.

The event code distinguishes read-type misses from write-type misses. Cache maintenance operations are sorted into one class or the other by operation. The new status register value raises privilege, blocks further exceptions and selects the alternate register bank, and leaves every other bit as it was. A miss arriving while exceptions are already blocked is not taken. Instead it is reported on a fatal pulse, and the saved state is left intact.

Top module: `dtlb_miss_entry`

## Requirements
- R1: After reset, every output is zero: event code, saved PC, saved status, saved R15, new status, redirect address, redirect-valid and fatal.
- R2: A request is accepted when `miss_req_i` is 1 and status bit 28 (exception block) is 0. On the edge that accepts it, every saved-state output and the redirect address are updated, so the new values are visible in the following cycle.
- R3: The `access_op_i` encoding is 0 load, 1 store, 2 cache purge, 3 cache write-back, 4 cache invalidate and 5 allocating store; codes 6 and 7 count as load. An accepted miss for load, purge or write-back loads event code 0x040. An accepted miss for store, invalidate or allocating store loads 0x060.
- R4: The saved PC takes `fault_pc_i` when `delay_slot_i` is 0 and `branch_pc_i` when it is 1.
- R5: The saved status takes `sr_i` as it was before the exception, and the saved R15 takes `r15_i`.
- R6: In the new status value, bit 30 (privileged mode), bit 28 (exception block) and bit 29 (register bank) are all 1.
- R7: Every status bit other than 30, 29 and 28 in the new status value equals the corresponding bit of `sr_i`.
- R8: The redirect address is `vbr_i + 0x00000400` (modulo 2^32).
- R9: `redirect_valid_o` is 1 for exactly the one cycle after each accepted request and is 0 otherwise.
- R10: A request with status bit 28 already 1 raises `fatal_o` for the one following cycle. It gives no redirect pulse and leaves every saved-state output and the new status value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_req_i | input | 1 | Data TLB miss request |
| access_op_i | input | 3 | Class of the faulting access |
| fault_pc_i | input | 32 | PC of the faulting instruction |
| branch_pc_i | input | 32 | PC of the delayed branch owning the slot |
| delay_slot_i | input | 1 | Faulting instruction sits in a delay slot |
| sr_i | input | 32 | Current status register |
| r15_i | input | 32 | Current general register 15 |
| vbr_i | input | 32 | Vector base register |
| event_code_o | output | 12 | Exception event code |
| saved_pc_o | output | 32 | Saved PC |
| saved_sr_o | output | 32 | Saved status register |
| saved_r15_o | output | 32 | Saved general register 15 |
| sr_o | output | 32 | New status register value |
| redirect_pc_o | output | 32 | Handler fetch address |
| redirect_valid_o | output | 1 | One-cycle redirect strobe |
| fatal_o | output | 1 | Miss arrived with exceptions blocked |

## Verification
Each of the six access classes and one reserved code is driven with a distinct PC. This shows the read/write split for every operation, including the cache operations, which a split by load versus store alone would get wrong. The delay-slot flag is toggled with the fault and branch PCs set far apart, so that selecting the wrong PC is visible. Status patterns of all ones and of alternating bits, with the three control bits cleared, expose any leak of a forced bit into its neighbours or any dropped pass-through bit. A blocked request follows an accepted one with different inputs, so that an overwrite of the saved state would show.

// File: rtl/dtlb_miss_pkg.sv
package dtlb_miss_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_PURGE = 3'd2,
    OP_WBACK = 3'd3,
    OP_INVAL = 3'd4,
    OP_ALLOC = 3'd5
  } mem_op_e;

  localparam int unsigned EVT_W = 12;
  localparam logic [EVT_W-1:0] EVT_RD_MISS = 12'h040;
  localparam logic [EVT_W-1:0] EVT_WR_MISS = 12'h060;

  localparam int unsigned SR_MD_BIT = 30;
  localparam int unsigned SR_RB_BIT = 29;
  localparam int unsigned SR_BL_BIT = 28;
endpackage

// File: rtl/dtlb_access_class.sv
module dtlb_access_class
  import dtlb_miss_pkg::*;
(
  input  logic [2:0]       op_i,
  output logic             is_write_o,
  output logic [EVT_W-1:0] evt_o
);
  always_comb begin
    case (op_i)
      OP_STORE, OP_INVAL, OP_ALLOC: is_write_o = 1'b1;
      default:                      is_write_o = 1'b0;
    endcase
    evt_o = is_write_o ? EVT_WR_MISS : EVT_RD_MISS;
  end
endmodule

// File: rtl/dtlb_sr_update.sv
module dtlb_sr_update
  import dtlb_miss_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] sr_i,
  output logic [XLEN-1:0] sr_o
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b == SR_MD_BIT || b == SR_RB_BIT || b == SR_BL_BIT) begin : g_force
      assign sr_o[b] = 1'b1;
    end else begin : g_pass
      assign sr_o[b] = sr_i[b];
    end
  end
endmodule

// File: rtl/dtlb_save_regs.sv
module dtlb_save_regs
  import dtlb_miss_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sr_old_i,
  input  logic [XLEN-1:0]  r15_i,
  input  logic [XLEN-1:0]  sr_new_i,
  input  logic [XLEN-1:0]  vec_i,
  output logic [EVT_W-1:0] evt_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  sr_old_o,
  output logic [XLEN-1:0]  r15_o,
  output logic [XLEN-1:0]  sr_new_o,
  output logic [XLEN-1:0]  vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o    <= '0;
      pc_o     <= '0;
      sr_old_o <= '0;
      r15_o    <= '0;
      sr_new_o <= '0;
      vec_o    <= '0;
    end else if (load_i) begin
      evt_o    <= evt_i;
      pc_o     <= pc_i;
      sr_old_o <= sr_old_i;
      r15_o    <= r15_i;
      sr_new_o <= sr_new_i;
      vec_o    <= vec_i;
    end
  end
endmodule

// File: rtl/dtlb_miss_entry.sv
module dtlb_miss_entry
  import dtlb_miss_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_req_i,
  input  logic [2:0]       access_op_i,
  input  logic [XLEN-1:0]  fault_pc_i,
  input  logic [XLEN-1:0]  branch_pc_i,
  input  logic             delay_slot_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  r15_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic [EVT_W-1:0] event_code_o,
  output logic [XLEN-1:0]  saved_pc_o,
  output logic [XLEN-1:0]  saved_sr_o,
  output logic [XLEN-1:0]  saved_r15_o,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             redirect_valid_o,
  output logic             fatal_o
);
  localparam logic [XLEN-1:0] VecOff = XLEN'(VEC_OFFSET);

  logic             blocked;
  logic             accept;
  logic             fatal_d;
  logic             is_write;
  logic [EVT_W-1:0] evt_d;
  logic [XLEN-1:0]  sr_new;
  logic [XLEN-1:0]  pc_sel;
  logic [XLEN-1:0]  vec_addr;

  assign blocked  = sr_i[SR_BL_BIT];
  assign accept   = miss_req_i & ~blocked;
  assign fatal_d  = miss_req_i & blocked;
  assign pc_sel   = delay_slot_i ? branch_pc_i : fault_pc_i;
  assign vec_addr = vbr_i + VecOff;

  dtlb_access_class u_class (
    .op_i       (access_op_i),
    .is_write_o (is_write),
    .evt_o      (evt_d)
  );

  dtlb_sr_update #(.XLEN(XLEN)) u_sr_upd (
    .sr_i (sr_i),
    .sr_o (sr_new)
  );

  dtlb_save_regs #(.XLEN(XLEN)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .evt_i    (evt_d),
    .pc_i     (pc_sel),
    .sr_old_i (sr_i),
    .r15_i    (r15_i),
    .sr_new_i (sr_new),
    .vec_i    (vec_addr),
    .evt_o    (event_code_o),
    .pc_o     (saved_pc_o),
    .sr_old_o (saved_sr_o),
    .r15_o    (saved_r15_o),
    .sr_new_o (sr_o),
    .vec_o    (redirect_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_valid_o <= 1'b0;
      fatal_o          <= 1'b0;
    end else begin
      redirect_valid_o <= accept;
      fatal_o          <= fatal_d;
    end
  end
endmodule

// File: rtl/dtlb_miss_entry_chk.sv
module dtlb_miss_entry_chk
  import dtlb_miss_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             miss_req_i,
  input logic [2:0]       access_op_i,
  input logic [XLEN-1:0]  fault_pc_i,
  input logic [XLEN-1:0]  branch_pc_i,
  input logic             delay_slot_i,
  input logic [XLEN-1:0]  sr_i,
  input logic [XLEN-1:0]  r15_i,
  input logic [XLEN-1:0]  vbr_i,
  input logic [EVT_W-1:0] event_code_o,
  input logic [XLEN-1:0]  saved_pc_o,
  input logic [XLEN-1:0]  saved_sr_o,
  input logic [XLEN-1:0]  saved_r15_o,
  input logic [XLEN-1:0]  sr_o,
  input logic [XLEN-1:0]  redirect_pc_o,
  input logic             redirect_valid_o,
  input logic             fatal_o
);
  logic tk, bk, wr_op;
  logic [XLEN-1:0] keep_mask;
  assign tk    = miss_req_i && !sr_i[SR_BL_BIT];
  assign bk    = miss_req_i && sr_i[SR_BL_BIT];
  assign wr_op = (access_op_i == 3'd1) || (access_op_i == 3'd4) || (access_op_i == 3'd5);
  always_comb begin
    keep_mask = '1;
    keep_mask[SR_MD_BIT] = 1'b0;
    keep_mask[SR_RB_BIT] = 1'b0;
    keep_mask[SR_BL_BIT] = 1'b0;
  end

  AST_EVT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tk && wr_op) |=> event_code_o == 12'h060); // R3
  AST_EVT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tk && !wr_op) |=> event_code_o == 12'h040); // R3
  AST_SAVED_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |=> saved_pc_o == ($past(delay_slot_i) ? $past(branch_pc_i) : $past(fault_pc_i))); // R4
  AST_SAVED_CTX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |=> (saved_sr_o == $past(sr_i)) && (saved_r15_o == $past(r15_i))); // R5
  AST_SR_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |=> sr_o[SR_MD_BIT] && sr_o[SR_BL_BIT] && sr_o[SR_RB_BIT]); // R6
  AST_SR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |=> (sr_o & keep_mask) == ($past(sr_i) & keep_mask)); // R7
  AST_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |=> redirect_pc_o == $past(vbr_i) + 32'h0000_0400); // R8
  AST_REDIR_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |=> redirect_valid_o); // R9
  AST_REDIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tk |=> !redirect_valid_o); // R9
  AST_FATAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk |=> fatal_o && $stable(saved_pc_o) && $stable(saved_sr_o) && $stable(sr_o)
           && $stable(event_code_o) && $stable(saved_r15_o)); // R10
  AST_FATAL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bk |=> !fatal_o); // R10
endmodule

bind dtlb_miss_entry dtlb_miss_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/dtlb_miss_entry_bench.sv
module dtlb_miss_entry_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_req_i = 1'b0;
  logic [2:0]  access_op_i = '0;
  logic [31:0] fault_pc_i = '0, branch_pc_i = '0, sr_i = '0, r15_i = '0, vbr_i = '0;
  logic        delay_slot_i = 1'b0;
  logic [11:0] event_code_o;
  logic [31:0] saved_pc_o, saved_sr_o, saved_r15_o, sr_o, redirect_pc_o;
  logic        redirect_valid_o, fatal_o;

  int checks = 0;
  int failures = 0;
  localparam logic [31:0] CTL = 32'h7000_0000;

  always #2 clk_i = ~clk_i;

  dtlb_miss_entry u_dtlb_miss_entry (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the next posedge
  task automatic issue(input logic [2:0] op, input logic ds, input logic [31:0] fpc,
                       input logic [31:0] bpc, input logic [31:0] sr,
                       input logic [31:0] r15, input logic [31:0] vbr);
    @(negedge clk_i);
    miss_req_i = 1'b1; access_op_i = op; delay_slot_i = ds;
    fault_pc_i = fpc; branch_pc_i = bpc; sr_i = sr; r15_i = r15; vbr_i = vbr;
    @(posedge clk_i); #1;
    miss_req_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 evt", 32'(event_code_o), 0);
    chk("R1 pc", saved_pc_o, 0);
    chk("R1 ssr", saved_sr_o, 0);
    chk("R1 sr15", saved_r15_o, 0);
    chk("R1 sr", sr_o, 0);
    chk("R1 vec", redirect_pc_o, 0);
    chk("R1 flags", {30'd0, redirect_valid_o, fatal_o}, 0);
  endtask

  task automatic t_classes();
    for (int op = 0; op < 7; op++) begin
      logic [31:0] e;
      e = (op == 1 || op == 4 || op == 5) ? 32'h060 : 32'h040;
      issue(3'(op), 1'b0, 32'h8000_1000 + 32'(op * 4), 32'h0, 32'h0, 32'h0, 32'h0);
      chk("R3 evt", 32'(event_code_o), e);
      chk("R2 pc", saved_pc_o, 32'h8000_1000 + 32'(op * 4));
    end
  endtask

  task automatic t_delay_slot();
    issue(3'd1, 1'b1, 32'h1111_2222, 32'hAAAA_0000, 32'h0, 32'h0, 32'h0);
    chk("R4 branch pc", saved_pc_o, 32'hAAAA_0000);
    issue(3'd1, 1'b0, 32'h1111_2222, 32'hAAAA_0000, 32'h0, 32'h0, 32'h0);
    chk("R4 fault pc", saved_pc_o, 32'h1111_2222);
  endtask

  task automatic t_context();
    logic [31:0] s;
    s = 32'hFFFF_FFFF & ~CTL;
    issue(3'd0, 1'b0, 32'h0, 32'h0, s, 32'hDEAD_BEEF, 32'h8C00_0000);
    chk("R5 ssr", saved_sr_o, s);
    chk("R5 sgr", saved_r15_o, 32'hDEAD_BEEF);
    chk("R6 ctl bits", sr_o & CTL, CTL);
    chk("R7 pass ones", sr_o & ~CTL, s);
    chk("R8 vector", redirect_pc_o, 32'h8C00_0400);
    chk("R9 pulse on", 32'(redirect_valid_o), 1);
    @(posedge clk_i); #1;
    chk("R9 pulse off", 32'(redirect_valid_o), 0);
    s = 32'hA5A5_5A5A & ~CTL;
    issue(3'd2, 1'b0, 32'h0, 32'h0, s, 32'h0, 32'hFFFF_FC00);
    chk("R7 pass alt", sr_o & ~CTL, s);
    chk("R8 wrap", redirect_pc_o, 32'h0000_0000);
  endtask

  task automatic t_blocked();
    issue(3'd4, 1'b0, 32'h4000_0040, 32'h0, 32'h0000_00F0, 32'h1234_5678, 32'h100);
    issue(3'd0, 1'b1, 32'h9999_9999, 32'h7777_7777, 32'h1000_0003, 32'h5555_5555, 32'h200);
    chk("R10 fatal", 32'(fatal_o), 1);
    chk("R10 no redirect", 32'(redirect_valid_o), 0);
    chk("R10 evt kept", 32'(event_code_o), 32'h060);
    chk("R10 pc kept", saved_pc_o, 32'h4000_0040);
    chk("R10 ssr kept", saved_sr_o, 32'h0000_00F0);
    chk("R10 sgr kept", saved_r15_o, 32'h1234_5678);
    chk("R10 sr kept", sr_o, 32'h7000_00F0);
    chk("R10 vec kept", redirect_pc_o, 32'h500);
    @(posedge clk_i); #1;
    chk("R10 fatal drop", 32'(fatal_o), 0);
  endtask

  initial begin
    #50000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #9 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_classes();
    t_delay_slot();
    t_context();
    t_blocked();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule